// File: doc/BRIEF.md
# Attention Command Decoder

This block sits between a host's attention signal and the shared control block in memory. Each attention pulse makes it fetch one 16-bit command word, write that word back as zero, and apply the word to two unit state machines. One is the command unit (idle, suspended, active) and the other is the receive unit (idle, suspended, ready). The block then writes a rebuilt 16-bit status word.

One command word carries several things at once:
- a code field for each unit;
- four acknowledge bits that clear pending event flags;
- a reset bit that returns both units to their start state.

Two event inputs let the neighbouring units report a finished command or a received frame. The block latches these as flags until the host acknowledges them. Attention pulses that arrive while a word is being handled are counted, and each is served in turn.

The sequencer has five states:

| State | What the block does there | Leaves for |
|---|---|---|
| SEQ_IDLE | Waits for the pending count to be non-zero. | SEQ_FETCH |
| SEQ_FETCH | Raises the read request for one cycle. | SEQ_WAIT |
| SEQ_WAIT | Holds until read data is valid, then captures the word. | SEQ_CLEAR |
| SEQ_CLEAR | Writes zero to the command word. The unit states update at the end of this cycle. | SEQ_POST |
| SEQ_POST | Writes the status word and shows the error and walk strobes. | SEQ_IDLE |

Top module: `attn_cmd_decoder`

## Requirements
- R1: After reset the command unit reads 0 (idle) and the receive unit reads 1 (suspended). All event flags are clear, and no read request or write is issued.
- R2: An attention pulse sampled at clock edge c gives a one-cycle read request in the cycle after edge c+1. The cycle after read data is valid carries a write of 0x0000 with select 0 (command word). The next cycle carries a write with select 1 (status word), and the block then returns to idle.
- R3: Attention pulses that arrive while a word is in progress are counted, up to 2^PEND_W-1 outstanding. Each one produces its own complete fetch, clear and status sequence, in arrival order.
- R4: The command-unit code is bits 10:8. Code 1 sets the unit to active (2). Code 4 sets it to suspended (1) and sets the not-active flag (status bit 13). Code 0 leaves it unchanged.
- R5: The receive-unit code is bits 6:4. Codes 1 and 2 set the unit to idle (0). Codes 3 and 4 set it to suspended (1) and set the not-ready flag (status bit 12). Code 0 leaves it unchanged.
- R6: Command bits 15:12 acknowledge flags. Each set bit clears the flag in the same status position. The clear happens before any flag the same command raises.
- R7: A pulse on done_evt_i sets the flag at status bit 15, and a pulse on rx_evt_i sets the flag at bit 14, in any cycle. An event in the same cycle as an acknowledge of that flag leaves the flag set.
- R8: Command bit 7 acts after both code fields. It puts the command unit at idle (0) and the receive unit at suspended (1), and clears all four flags.
- R9: The status word holds the flags in bits 15:12, the command-unit state in bits 10:8 and the receive-unit state in bits 6:4. Every other bit is 0. It reflects the states after the command.
- R10: A command-unit code other than 0, 1 or 4 leaves that unit unchanged. So does a receive-unit code other than 0 to 4. Either case raises cmd_err_o for exactly the status-write cycle.
- R11: walk_start_o is high for exactly the status-write cycle when the command unit is active after the command, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn_i | input | 1 | Attention pulse, one per command |
| done_evt_i | input | 1 | Command-completed event from the command walker |
| rx_evt_i | input | 1 | Frame-received event from the receive side |
| cmd_rd_req_o | output | 1 | One-cycle request to read the command word |
| cmd_rd_valid_i | input | 1 | Read data valid |
| cmd_rd_data_i | input | 16 | Command word read data |
| scb_wr_en_o | output | 1 | Write strobe to the control block |
| scb_wr_sel_o | output | 1 | Write target: 0 command word, 1 status word |
| scb_wr_data_o | output | 16 | Write data |
| cu_state_o | output | 3 | Command-unit state (0 idle, 1 suspended, 2 active) |
| ru_state_o | output | 3 | Receive-unit state (0 idle, 1 suspended, 4 ready) |
| walk_start_o | output | 1 | Start-command-walk strobe |
| cmd_err_o | output | 1 | Unknown code strobe |

## Verification
The bench targets the following corner cases:
- Attention pulses landing back to back while a word is still in flight. A design that drops these runs fewer status writes than the pulses it was given.
- A word that both acknowledges and raises the same flag. A design that applies the acknowledge last would report that flag as clear.
- The reset bit combined with a start code. A design that applies the reset first would leave the command unit active.
- Read latencies of zero and several cycles, together with unknown codes. A decoder that moves a unit on a bad code, or that holds the error strobe outside the status write, differs from the cycle model on the next compare.

// File: rtl/attn_pkg.sv
package attn_pkg;

    localparam int WORD_W  = 16;
    localparam int FLAG_W  = 4;
    localparam int CODE_W  = 3;

    // field positions in the command and status words
    localparam int ACK_LSB = 12;
    localparam int CUC_LSB = 8;
    localparam int RUC_LSB = 4;
    localparam int RST_POS = 7;

    // flag index inside the four-bit flag group
    localparam int FL_DONE  = 3;
    localparam int FL_FRAME = 2;
    localparam int FL_CNA   = 1;
    localparam int FL_RNR   = 0;

    localparam logic [CODE_W-1:0] CUC_NOP     = 3'd0;
    localparam logic [CODE_W-1:0] CUC_START   = 3'd1;
    localparam logic [CODE_W-1:0] CUC_ABORT   = 3'd4;
    localparam logic [CODE_W-1:0] RUC_NOP     = 3'd0;
    localparam logic [CODE_W-1:0] RUC_START   = 3'd1;
    localparam logic [CODE_W-1:0] RUC_RESUME  = 3'd2;
    localparam logic [CODE_W-1:0] RUC_SUSPEND = 3'd3;
    localparam logic [CODE_W-1:0] RUC_ABORT   = 3'd4;

    typedef enum logic [CODE_W-1:0] {
        CU_IDLE = 3'd0,
        CU_SUSP = 3'd1,
        CU_ACT  = 3'd2
    } cu_state_t;

    typedef enum logic [CODE_W-1:0] {
        RU_IDLE  = 3'd0,
        RU_SUSP  = 3'd1,
        RU_READY = 3'd4
    } ru_state_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_FETCH,
        SEQ_WAIT,
        SEQ_CLEAR,
        SEQ_POST
    } seq_state_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [FLAG_W-1:0] fl,
        input cu_state_t         cu,
        input ru_state_t         ru
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[ACK_LSB +: FLAG_W] = fl;
        w[CUC_LSB +: CODE_W] = cu;
        w[RUC_LSB +: CODE_W] = ru;
        return w;
    endfunction

endpackage

// File: rtl/attn_pend_count.sv
module attn_pend_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump_i,
    input  logic take_i,
    output logic pending_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             drain;
    logic             accept;

    assign drain  = take_i && (cnt_q != '0);
    assign accept = bump_i && ((cnt_q != CNT_MAX) || drain);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept && !drain) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!accept && drain) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pending_o = (cnt_q != '0);

endmodule

// File: rtl/attn_seq.sv
module attn_seq
    import attn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic rd_valid_i,
    output logic take_o,
    output logic rd_req_o,
    output logic cap_o,
    output logic apply_o,
    output logic wr_en_o,
    output logic wr_sel_o
);
    seq_state_t state_q;
    seq_state_t state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (pending_i)  state_n = SEQ_FETCH;
            SEQ_FETCH: state_n = SEQ_WAIT;
            SEQ_WAIT:  if (rd_valid_i) state_n = SEQ_CLEAR;
            SEQ_CLEAR: state_n = SEQ_POST;
            SEQ_POST:  state_n = SEQ_IDLE;
            default:   state_n = SEQ_IDLE;
        endcase
    end

    always_comb begin
        take_o   = 1'b0;
        rd_req_o = 1'b0;
        cap_o    = 1'b0;
        apply_o  = 1'b0;
        wr_en_o  = 1'b0;
        wr_sel_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  take_o = pending_i;
            SEQ_FETCH: rd_req_o = 1'b1;
            SEQ_WAIT:  cap_o = rd_valid_i;
            SEQ_CLEAR: begin
                apply_o = 1'b1;
                wr_en_o = 1'b1;
            end
            SEQ_POST: begin
                wr_en_o  = 1'b1;
                wr_sel_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/attn_unit_ctl.sv
module attn_unit_ctl
    import attn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              done_evt_i,
    input  logic              rx_evt_i,
    output cu_state_t         cu_o,
    output ru_state_t         ru_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              err_o,
    output logic              walk_o
);
    cu_state_t         cu_q, cu_n;
    ru_state_t         ru_q, ru_n;
    logic [FLAG_W-1:0] fl_q, fl_n;
    logic              err_q, walk_q;
    logic              bad_n;
    logic [CODE_W-1:0] cuc;
    logic [CODE_W-1:0] ruc;
    logic              unused_bits;

    assign cuc         = word_i[CUC_LSB +: CODE_W];
    assign ruc         = word_i[RUC_LSB +: CODE_W];
    assign unused_bits = ^{word_i[11], word_i[3:0]};

    always_comb begin
        cu_n  = cu_q;
        ru_n  = ru_q;
        fl_n  = fl_q;
        bad_n = 1'b0;
        if (apply_i) begin
            // acknowledges first, so a flag raised by the same word survives
            fl_n = fl_q & ~word_i[ACK_LSB +: FLAG_W];
            unique case (cuc)
                CUC_NOP:   cu_n = cu_q;
                CUC_START: cu_n = CU_ACT;
                CUC_ABORT: begin
                    cu_n         = CU_SUSP;
                    fl_n[FL_CNA] = 1'b1;
                end
                default:   bad_n = 1'b1;
            endcase
            unique case (ruc)
                RUC_NOP:                ru_n = ru_q;
                RUC_START, RUC_RESUME:  ru_n = RU_IDLE;
                RUC_SUSPEND, RUC_ABORT: begin
                    ru_n         = RU_SUSP;
                    fl_n[FL_RNR] = 1'b1;
                end
                default:                bad_n = 1'b1;
            endcase
        end
        fl_n[FL_DONE]  = fl_n[FL_DONE]  | done_evt_i;
        fl_n[FL_FRAME] = fl_n[FL_FRAME] | rx_evt_i;
        if (apply_i && word_i[RST_POS]) begin
            cu_n = CU_IDLE;
            ru_n = RU_SUSP;
            fl_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cu_q   <= CU_IDLE;
            ru_q   <= RU_SUSP;
            fl_q   <= '0;
            err_q  <= 1'b0;
            walk_q <= 1'b0;
        end else begin
            cu_q <= cu_n;
            ru_q <= ru_n;
            fl_q <= fl_n;
            if (apply_i) begin
                err_q  <= bad_n;
                walk_q <= (cu_n == CU_ACT);
            end
        end
    end

    assign cu_o    = cu_q;
    assign ru_o    = ru_q;
    assign flags_o = fl_q;
    assign err_o   = err_q;
    assign walk_o  = walk_q;

endmodule

// File: rtl/attn_cmd_decoder.sv
module attn_cmd_decoder
    import attn_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attn_i,
    input  logic              done_evt_i,
    input  logic              rx_evt_i,
    output logic              cmd_rd_req_o,
    input  logic              cmd_rd_valid_i,
    input  logic [WORD_W-1:0] cmd_rd_data_i,
    output logic              scb_wr_en_o,
    output logic              scb_wr_sel_o,
    output logic [WORD_W-1:0] scb_wr_data_o,
    output logic [CODE_W-1:0] cu_state_o,
    output logic [CODE_W-1:0] ru_state_o,
    output logic              walk_start_o,
    output logic              cmd_err_o
);
    logic              pending, take, cap, apply_en, wr_en, wr_sel;
    logic [WORD_W-1:0] word_q;
    cu_state_t         cu;
    ru_state_t         ru;
    logic [FLAG_W-1:0] flags;
    logic              err_l, walk_l;
    logic              post;

    attn_pend_count #(.CNT_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .bump_i    (attn_i),
        .take_i    (take),
        .pending_o (pending)
    );

    attn_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_i  (pending),
        .rd_valid_i (cmd_rd_valid_i),
        .take_o     (take),
        .rd_req_o   (cmd_rd_req_o),
        .cap_o      (cap),
        .apply_o    (apply_en),
        .wr_en_o    (wr_en),
        .wr_sel_o   (wr_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap) begin
            word_q <= cmd_rd_data_i;
        end
    end

    attn_unit_ctl u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply_i    (apply_en),
        .word_i     (word_q),
        .done_evt_i (done_evt_i),
        .rx_evt_i   (rx_evt_i),
        .cu_o       (cu),
        .ru_o       (ru),
        .flags_o    (flags),
        .err_o      (err_l),
        .walk_o     (walk_l)
    );

    assign post          = wr_en && wr_sel;
    assign scb_wr_en_o   = wr_en;
    assign scb_wr_sel_o  = wr_sel;
    assign scb_wr_data_o = post ? pack_status(flags, cu, ru) : '0;
    assign cu_state_o    = cu;
    assign ru_state_o    = ru;
    assign walk_start_o  = post && walk_l;
    assign cmd_err_o     = post && err_l;

endmodule

// File: rtl/attn_cmd_decoder_chk.sv
module attn_cmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_rd_req_o,
    input logic        scb_wr_en_o,
    input logic        scb_wr_sel_o,
    input logic [15:0] scb_wr_data_o,
    input logic [2:0]  cu_state_o,
    input logic [2:0]  ru_state_o,
    input logic        walk_start_o,
    input logic        cmd_err_o
);
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd_req_o |=> !cmd_rd_req_o);

    p_clear_then_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scb_wr_en_o && !scb_wr_sel_o) |=> (scb_wr_en_o && scb_wr_sel_o));

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scb_wr_en_o && !scb_wr_sel_o) |-> (scb_wr_data_o == 16'h0000));

    p_cu_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state_o inside {3'd0, 3'd1, 3'd2});

    p_ru_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ru_state_o inside {3'd0, 3'd1, 3'd4});

    p_units_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(scb_wr_en_o && !scb_wr_sel_o) |=> ($stable(cu_state_o) && $stable(ru_state_o)));

    p_status_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scb_wr_en_o && scb_wr_sel_o) |->
            (scb_wr_data_o[10:8] == cu_state_o && scb_wr_data_o[6:4] == ru_state_o
             && scb_wr_data_o[11] == 1'b0 && scb_wr_data_o[7] == 1'b0
             && scb_wr_data_o[3:0] == 4'h0));

    p_err_in_post_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> (scb_wr_en_o && scb_wr_sel_o));

    p_walk_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start_o |-> (scb_wr_en_o && scb_wr_sel_o && cu_state_o == 3'd2));

endmodule

bind attn_cmd_decoder attn_cmd_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_rd_req_o  (cmd_rd_req_o),
    .scb_wr_en_o   (scb_wr_en_o),
    .scb_wr_sel_o  (scb_wr_sel_o),
    .scb_wr_data_o (scb_wr_data_o),
    .cu_state_o    (cu_state_o),
    .ru_state_o    (ru_state_o),
    .walk_start_o  (walk_start_o),
    .cmd_err_o     (cmd_err_o)
);

// File: tb/attn_cmd_decoder_bench.sv
module attn_cmd_decoder_bench;
    localparam int PEND_W = 4;
    localparam int MAXP   = (1 << PEND_W) - 1;
    localparam int WD_LIM = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        attn_i = 1'b0;
    logic        done_evt_i = 1'b0;
    logic        rx_evt_i = 1'b0;
    logic        cmd_rd_req_o;
    logic        cmd_rd_valid_i = 1'b0;
    logic [15:0] cmd_rd_data_i = 16'h0;
    logic        scb_wr_en_o, scb_wr_sel_o;
    logic [15:0] scb_wr_data_o;
    logic [2:0]  cu_state_o, ru_state_o;
    logic        walk_start_o, cmd_err_o;

    always #5 clk = ~clk;

    attn_cmd_decoder #(.PEND_W(PEND_W)) u_attn_cmd_decoder (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // command memory responder
    logic [15:0] cmd_q[$];
    int resp_cnt = -1;
    int resp_lat = 0;
    always @(negedge clk) begin
        cmd_rd_valid_i = 1'b0;
        if (resp_cnt == 0) begin
            cmd_rd_valid_i = 1'b1;
            cmd_rd_data_i  = (cmd_q.size() > 0) ? cmd_q.pop_front() : 16'h0;
            resp_cnt = -1;
        end else if (resp_cnt > 0) begin
            resp_cnt--;
        end
        if (cmd_rd_req_o) resp_cnt = resp_lat;
    end

    // behavioural reference model, advanced on each rising edge
    int m_phase, m_pend, m_cu, m_ru, m_fl, m_err, m_walk;
    logic [15:0] m_word;
    int old_phase, take, nf, cuc, ruc, bd;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_pend = 0; m_cu = 0; m_ru = 1; m_fl = 0;
            m_err = 0; m_walk = 0; m_word = 16'h0;
        end else begin
            old_phase = m_phase;
            take = (m_phase == 0 && m_pend > 0) ? 1 : 0;
            case (m_phase)
                0: if (m_pend > 0) m_phase = 1;
                1: m_phase = 2;
                2: if (cmd_rd_valid_i) begin m_word = cmd_rd_data_i; m_phase = 3; end
                3: m_phase = 4;
                default: m_phase = 0;
            endcase
            nf = m_fl;
            bd = 0;
            if (old_phase == 3) begin
                nf = nf & ~((m_word >> 12) & 15);
                cuc = (m_word >> 8) & 7;
                ruc = (m_word >> 4) & 7;
                if (cuc == 1) m_cu = 2;
                else if (cuc == 4) begin m_cu = 1; nf = nf | 2; end
                else if (cuc != 0) bd = 1;
                if (ruc == 1 || ruc == 2) m_ru = 0;
                else if (ruc == 3 || ruc == 4) begin m_ru = 1; nf = nf | 1; end
                else if (ruc != 0) bd = 1;
            end
            if (done_evt_i) nf = nf | 8;
            if (rx_evt_i)   nf = nf | 4;
            if (old_phase == 3 && m_word[7]) begin m_cu = 0; m_ru = 1; nf = 0; end
            if (old_phase == 3) begin m_err = bd; m_walk = (m_cu == 2) ? 1 : 0; end
            m_fl = nf;
            if (attn_i && (m_pend < MAXP || take == 1)) m_pend++;
            if (take == 1) m_pend--;
        end
        if (cyc > WD_LIM && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, WD_LIM);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // per-cycle compare and status capture
    logic [15:0] last_status = 16'h0;
    logic        last_err = 0, last_walk = 0;
    int          stat_cnt = 0;
    logic [15:0] stat_log[$];
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "rd_req", cmd_rd_req_o, (m_phase == 1) ? 1 : 0);
            chk("R2", "wr_en", scb_wr_en_o, (m_phase == 3 || m_phase == 4) ? 1 : 0);
            chk("R2", "wr_sel", scb_wr_sel_o, (m_phase == 4) ? 1 : 0);
            chk("R9", "wr_data", scb_wr_data_o,
                (m_phase == 4) ? ((m_fl << 12) | (m_cu << 8) | (m_ru << 4)) : 0);
            chk("R4", "cu_state", cu_state_o, m_cu);
            chk("R5", "ru_state", ru_state_o, m_ru);
            chk("R10", "err", cmd_err_o, (m_phase == 4) ? m_err : 0);
            chk("R11", "walk", walk_start_o, (m_phase == 4) ? m_walk : 0);
            if (scb_wr_en_o && scb_wr_sel_o) begin
                last_status = scb_wr_data_o;
                last_err    = cmd_err_o;
                last_walk   = walk_start_o;
                stat_log.push_back(scb_wr_data_o);
                stat_cnt++;
            end
        end
    end

    task automatic run_cmd(input logic [15:0] w, input int lat);
        int target;
        resp_lat = lat;
        cmd_q.push_back(w);
        target = stat_cnt + 1;
        @(negedge clk) attn_i = 1'b1;
        @(negedge clk) attn_i = 1'b0;
        while (stat_cnt < target) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cu after reset", cu_state_o, 0);
        chk("R1", "ru after reset", ru_state_o, 1);
        chk("R1", "no request", {cmd_rd_req_o, scb_wr_en_o}, 0);

        run_cmd(16'h0100, 0);
        chk("R4", "start cu status", last_status, 16'h0210);
        chk("R11", "walk on active", last_walk, 1);
        run_cmd(16'h0010, 1);
        chk("R5", "ru start status", last_status, 16'h0200);
        run_cmd(16'h0430, 3);
        chk("R4", "abort cu + suspend ru", last_status, 16'h3110);
        chk("R11", "no walk when suspended", last_walk, 0);
        run_cmd(16'h2020, 2);
        chk("R6", "ack not-active, resume ru", last_status, 16'h1100);

        @(negedge clk) begin done_evt_i = 1'b1; rx_evt_i = 1'b1; end
        @(negedge clk) begin done_evt_i = 1'b0; rx_evt_i = 1'b0; end
        run_cmd(16'h0000, 0);
        chk("R7", "event flags", last_status, 16'hD100);
        run_cmd(16'h5000, 1);
        chk("R6", "ack frame and not-ready", last_status, 16'h8100);

        run_cmd(16'h0300, 0);
        chk("R10", "bad cu code status", last_status, 16'h8100);
        chk("R10", "bad cu code err", last_err, 1);
        run_cmd(16'h0050, 2);
        chk("R10", "bad ru code status", last_status, 16'h8100);
        chk("R10", "bad ru code err", last_err, 1);

        run_cmd(16'h0180, 1);
        chk("R8", "reset bit status", last_status, 16'h0010);
        chk("R8", "reset bit walk", last_walk, 0);

        begin
            int target;
            resp_lat = 2;
            cmd_q.push_back(16'h0110);
            cmd_q.push_back(16'h0040);
            cmd_q.push_back(16'h0400);
            stat_log.delete();
            target = stat_cnt + 3;
            @(negedge clk) attn_i = 1'b1;
            @(negedge clk) attn_i = 1'b1;
            @(negedge clk) attn_i = 1'b0;
            repeat (4) @(negedge clk);
            attn_i = 1'b1;
            @(negedge clk) attn_i = 1'b0;
            while (stat_cnt < target) @(posedge clk);
            repeat (10) @(negedge clk);
            chk("R3", "status writes for 3 pulses", stat_log.size(), 3);
            chk("R3", "first queued", (stat_log.size() > 0) ? stat_log[0] : 16'hxxxx, 16'h0200);
            chk("R3", "second queued", (stat_log.size() > 1) ? stat_log[1] : 16'hxxxx, 16'h1210);
            chk("R3", "third queued", (stat_log.size() > 2) ? stat_log[2] : 16'hxxxx, 16'h3110);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule